// File: doc/BRIEF.md
# Shared-Memory Per-Flow Queue Manager

This block holds an independent first-in first-out queue for each of several flows, all drawn from one common pool of storage slots. Each slot stores a data word and the index of the slot that follows it, so a flow's queue is a singly linked chain. A per-flow table keeps a head index (oldest word) and a tail index. The tail always names a spare, still-empty slot that the next arriving word will fill. Unused slots sit in a circular list of free indices. A word of any flow may land in any slot.

A producer offers words through a valid/ready enqueue port tagged with a flow number. A consumer asks for the oldest word of a named flow through a valid/ready dequeue port. The word comes back with a one-cycle valid strobe and its flow number. The block works on one request at a time, and every request takes the same number of cycles. A transmit-enable input can hold all dequeues off while enqueues continue.

After reset, flow f owns slot f as its spare slot, with head equal to tail. The free list holds every remaining slot index in ascending order. The block can therefore hold NUM_SLOTS − NUM_FLOWS words at once, spread over the flows in any proportion.

Top module: `flowQueueMgr`

## Requirements
- R1: After synchronous reset (rst high at a clock edge), outValid, deqErr and enqFull are low and enqReady is high. deqReady equals txEnable while enqValid is low.
- R2: Words dequeued from a flow come out in the order they were enqueued to that flow. Traffic on other flows does not change this order or the values.
- R3: A request is accepted at the rising edge where its valid and ready are both high. Its single-cycle result pulse (outValid with outFlow/outData, deqErr, or enqFull) is visible after the next rising edge. A successful enqueue produces no pulse.
- R4: A dequeue of a flow whose head equals its tail (empty) gives a deqErr pulse and no outValid. No queue or free-list state changes.
- R5: An enqueue while the free list is empty gives an enqFull pulse. The word is discarded and no queue content changes.
- R6: The block holds exactly NUM_SLOTS − NUM_FLOWS words in total. A slot released by a dequeue can be reused by a later enqueue of any flow.
- R7: While txEnable is low, deqReady is low, no dequeue is accepted and queued data stays intact.
- R8: In the cycle after an accepted request, enqReady and deqReady are both low. Readiness returns one cycle later.
- R9: When enqValid is high and the block is idle, deqReady is low. A simultaneous enqueue is therefore served before the dequeue.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| txEnable | input | 1 | Permits dequeues when high |
| enqValid | input | 1 | Enqueue request |
| enqReady | output | 1 | Enqueue request may be taken |
| enqFlow | input | FLOW_W | Flow of the word to store |
| enqData | input | DATA_W | Word to store |
| deqValid | input | 1 | Dequeue request |
| deqReady | output | 1 | Dequeue request may be taken |
| deqFlow | input | FLOW_W | Flow to read from |
| outValid | output | 1 | Dequeued word strobe |
| outFlow | output | FLOW_W | Flow of the dequeued word |
| outData | output | DATA_W | Dequeued word |
| deqErr | output | 1 | Dequeue refused, flow empty |
| enqFull | output | 1 | Enqueue refused, no free slot |

## Verification
An enqueue and a dequeue can be requested in the same cycle, and both would contend for the single execution slot and for the free list. The bench raises both valids on one edge, aimed at a flow that is still empty. It expects deqReady to be held low while the enqueue is taken. It then expects the waiting dequeue to return the new word, not an empty-flow error. A wrong arbitration shows up as a deqErr or as both requests taken at once.

// File: rtl/flowQueuePkg.sv
package flowQueuePkg;
  // Strobes sent from the sequencer to the storage datapath
  typedef struct packed {
    logic capEnq;   // latch enqueue operands
    logic capDeq;   // latch dequeue operand
    logic runEnq;   // perform the latched enqueue
    logic runDeq;   // perform the latched dequeue
  } qmStrobe_t;

  typedef enum logic {ST_IDLE, ST_EXEC} qmState_t;
endpackage

// File: rtl/flowQueueCtrl.sv
module flowQueueCtrl
  import flowQueuePkg::*;
(
  input  logic      clk,
  input  logic      rst,
  input  logic      txEnable,
  input  logic      enqValid,
  input  logic      deqValid,
  output logic      enqReady,
  output logic      deqReady,
  output qmStrobe_t strobe
);
  qmState_t state;
  logic     opDeq;

  assign enqReady = (state == ST_IDLE);
  // enqueue has priority; dequeue also gated by transmit enable
  assign deqReady = (state == ST_IDLE) && txEnable && !enqValid;

  assign strobe.capEnq = enqValid && enqReady;
  assign strobe.capDeq = deqValid && deqReady;
  assign strobe.runEnq = (state == ST_EXEC) && !opDeq;
  assign strobe.runDeq = (state == ST_EXEC) && opDeq;

  always_ff @(posedge clk) begin
    if (rst) begin
      state <= ST_IDLE;
      opDeq <= 1'b0;
    end else begin
      case (state)
        ST_IDLE: if (strobe.capEnq || strobe.capDeq) begin
          state <= ST_EXEC;
          opDeq <= strobe.capDeq;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  // R8: one request in flight; both ports blocked the cycle after acceptance
  a_r8_single_issue: assert property (@(posedge clk) disable iff (rst)
    (strobe.capEnq || strobe.capDeq) |=> (!enqReady && !deqReady));
  // R8: readiness comes back one cycle after the execute cycle
  a_r8_ready_returns: assert property (@(posedge clk) disable iff (rst)
    (strobe.runEnq || strobe.runDeq) |=> enqReady);
  // R7: no dequeue is offered while transmit is off
  a_r7_tx_gate: assert property (@(posedge clk) disable iff (rst)
    !txEnable |-> !deqReady);
  // R9: a pending enqueue blocks the dequeue port
  a_r9_enq_first: assert property (@(posedge clk) disable iff (rst)
    (enqValid && enqReady) |-> !deqReady);
endmodule

// File: rtl/flowQueueData.sv
module flowQueueData
  import flowQueuePkg::*;
#(
  parameter int NUM_FLOWS = 4,
  parameter int NUM_SLOTS = 16,
  parameter int DATA_W    = 16,
  localparam int FLOW_W   = (NUM_FLOWS > 1) ? $clog2(NUM_FLOWS) : 1,
  localparam int SLOT_W   = $clog2(NUM_SLOTS),
  localparam int CNT_W    = $clog2(NUM_SLOTS + 1),
  localparam int CAPACITY = NUM_SLOTS - NUM_FLOWS
) (
  input  logic              clk,
  input  logic              rst,
  input  qmStrobe_t         strobe,
  input  logic [FLOW_W-1:0] enqFlow,
  input  logic [DATA_W-1:0] enqData,
  input  logic [FLOW_W-1:0] deqFlow,
  output logic              outValid,
  output logic [FLOW_W-1:0] outFlow,
  output logic [DATA_W-1:0] outData,
  output logic              deqErr,
  output logic              enqFull
);
  logic [FLOW_W-1:0] curFlow;
  logic [DATA_W-1:0] curData;

  logic [DATA_W-1:0] slotData [NUM_SLOTS];
  logic [SLOT_W-1:0] slotNext [NUM_SLOTS];
  logic [SLOT_W-1:0] headTab  [NUM_FLOWS];
  logic [SLOT_W-1:0] tailTab  [NUM_FLOWS];
  logic [SLOT_W-1:0] freeList [NUM_SLOTS];
  logic [SLOT_W-1:0] freeRd, freeWr;
  logic [CNT_W-1:0]  freeCount;

  logic [SLOT_W-1:0] curHead, curTail, newSlot;
  logic              flowEmpty, freeEmpty, doStore, doFetch;

  assign curHead   = headTab[curFlow];
  assign curTail   = tailTab[curFlow];
  assign newSlot   = freeList[freeRd];
  assign flowEmpty = (curHead == curTail);
  assign freeEmpty = (freeCount == '0);
  assign doStore   = strobe.runEnq && !freeEmpty;
  assign doFetch   = strobe.runDeq && !flowEmpty;

  function automatic logic [SLOT_W-1:0] wrapInc(input logic [SLOT_W-1:0] p);
    return (p == SLOT_W'(NUM_SLOTS - 1)) ? '0 : p + 1'b1;
  endfunction

  // operand capture
  always_ff @(posedge clk) begin
    if (rst) begin
      curFlow <= '0;
      curData <= '0;
    end else if (strobe.capEnq) begin
      curFlow <= enqFlow;
      curData <= enqData;
    end else if (strobe.capDeq) begin
      curFlow <= deqFlow;
    end
  end

  // slot storage (no reset needed: only linked slots are read)
  always_ff @(posedge clk) begin
    if (doStore) begin
      slotData[curTail] <= curData;
      slotNext[curTail] <= newSlot;
    end
  end

  // flow table, free list, result pulses
  always_ff @(posedge clk) begin
    if (rst) begin
      for (int f = 0; f < NUM_FLOWS; f++) begin
        headTab[f] <= SLOT_W'(f);
        tailTab[f] <= SLOT_W'(f);
      end
      for (int k = 0; k < NUM_SLOTS; k++)
        freeList[k] <= (k < CAPACITY) ? SLOT_W'(k + NUM_FLOWS) : '0;
      freeRd    <= '0;
      freeWr    <= SLOT_W'(CAPACITY);
      freeCount <= CNT_W'(CAPACITY);
      outValid  <= 1'b0;
      outFlow   <= '0;
      outData   <= '0;
      deqErr    <= 1'b0;
      enqFull   <= 1'b0;
    end else begin
      outValid <= doFetch;
      deqErr   <= strobe.runDeq && flowEmpty;
      enqFull  <= strobe.runEnq && freeEmpty;
      if (doStore) begin
        tailTab[curFlow] <= newSlot;
        freeRd           <= wrapInc(freeRd);
        freeCount        <= freeCount - 1'b1;
      end
      if (doFetch) begin
        outFlow          <= curFlow;
        outData          <= slotData[curHead];
        headTab[curFlow] <= slotNext[curHead];
        freeList[freeWr] <= curHead;
        freeWr           <= wrapInc(freeWr);
        freeCount        <= freeCount + 1'b1;
      end
    end
  end

  // R4: an error pulse never comes with a data strobe
  a_r4_err_exclusive: assert property (@(posedge clk) disable iff (rst)
    !(deqErr && outValid));
  // R4: a refused dequeue leaves the free list untouched
  a_r4_no_free_change: assert property (@(posedge clk) disable iff (rst)
    deqErr |-> $stable(freeCount));
  // R5: a full refusal only while no slot is free, and nothing was taken
  a_r5_full_when_empty: assert property (@(posedge clk) disable iff (rst)
    enqFull |-> (freeCount == '0));
  // R6: free count stays within the pool that flows do not reserve
  a_r6_count_bound: assert property (@(posedge clk) disable iff (rst)
    freeCount <= CNT_W'(CAPACITY));
  // R3: at most one result pulse per cycle
  a_r3_one_result: assert property (@(posedge clk) disable iff (rst)
    $onehot0({outValid, deqErr, enqFull}));
endmodule

// File: rtl/flowQueueMgr.sv
module flowQueueMgr
  import flowQueuePkg::*;
#(
  parameter int NUM_FLOWS = 4,
  parameter int NUM_SLOTS = 16,
  parameter int DATA_W    = 16,
  localparam int FLOW_W   = (NUM_FLOWS > 1) ? $clog2(NUM_FLOWS) : 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              txEnable,
  input  logic              enqValid,
  output logic              enqReady,
  input  logic [FLOW_W-1:0] enqFlow,
  input  logic [DATA_W-1:0] enqData,
  input  logic              deqValid,
  output logic              deqReady,
  input  logic [FLOW_W-1:0] deqFlow,
  output logic              outValid,
  output logic [FLOW_W-1:0] outFlow,
  output logic [DATA_W-1:0] outData,
  output logic              deqErr,
  output logic              enqFull
);
  qmStrobe_t strobe;

  flowQueueCtrl ctrl_i (
    .clk(clk), .rst(rst), .txEnable(txEnable),
    .enqValid(enqValid), .deqValid(deqValid),
    .enqReady(enqReady), .deqReady(deqReady), .strobe(strobe)
  );

  flowQueueData #(.NUM_FLOWS(NUM_FLOWS), .NUM_SLOTS(NUM_SLOTS), .DATA_W(DATA_W)) data_i (
    .clk(clk), .rst(rst), .strobe(strobe),
    .enqFlow(enqFlow), .enqData(enqData), .deqFlow(deqFlow),
    .outValid(outValid), .outFlow(outFlow), .outData(outData),
    .deqErr(deqErr), .enqFull(enqFull)
  );
endmodule

// File: tb/flowQueueMgr_tb_top.sv
module flowQueueMgr_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int NF = 4;
  localparam int NS = 16;
  localparam int DW = 16;
  localparam int FW = 2;
  localparam int CAP = NS - NF;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic txEnable = 1'b1;
  logic enqValid = 1'b0, deqValid = 1'b0;
  logic [FW-1:0] enqFlow = '0, deqFlow = '0;
  logic [DW-1:0] enqData = '0;
  logic enqReady, deqReady, outValid, deqErr, enqFull;
  logic [FW-1:0] outFlow;
  logic [DW-1:0] outData;

  int compared = 0;
  int mismatched = 0;
  int cycles = 0;
  bit finished = 0;

  // scoreboard: kind 0 = data word, 1 = empty error, 2 = full refusal
  int expKind[$];
  int expFlow[$];
  int expData[$];
  int model[NF][$];
  int held = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  flowQueueMgr #(.NUM_FLOWS(NF), .NUM_SLOTS(NS), .DATA_W(DW)) dut_i (
    .clk(clk), .rst(rst), .txEnable(txEnable),
    .enqValid(enqValid), .enqReady(enqReady), .enqFlow(enqFlow), .enqData(enqData),
    .deqValid(deqValid), .deqReady(deqReady), .deqFlow(deqFlow),
    .outValid(outValid), .outFlow(outFlow), .outData(outData),
    .deqErr(deqErr), .enqFull(enqFull)
  );

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    compared++;
    if (!ok) begin
      mismatched++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  // monitor: every result pulse is popped and compared against the scoreboard
  always @(negedge clk) begin
    if (!rst && (outValid || deqErr || enqFull)) begin
      int k;
      k = outValid ? 0 : (deqErr ? 1 : 2);
      if (expKind.size() == 0) begin
        check(0, "R3 unexpected result pulse", k, -1);
      end else begin
        int ek, ef, ed;
        ek = expKind.pop_front(); ef = expFlow.pop_front(); ed = expData.pop_front();
        check(k == ek, "R4/R5 result kind", k, ek);
        if (ek == 0 && k == 0) begin
          check(int'(outFlow) == ef, "R3 outFlow", int'(outFlow), ef);
          check(int'(outData) == ed, "R2 outData order", int'(outData), ed);
        end
      end
    end
  end

  // called at a negedge; returns at the negedge where the result is visible
  task automatic doEnq(input int f, input int d);
    enqValid = 1'b1; enqFlow = FW'(f); enqData = DW'(d);
    #1;
    while (!enqReady) begin @(negedge clk); #1; end
    if (held < CAP) begin
      model[f].push_back(d); held++;
    end else begin
      expKind.push_back(2); expFlow.push_back(f); expData.push_back(0);
    end
    @(negedge clk);
    enqValid = 1'b0;
    #1;
    check(!enqReady && !deqReady, "R8 busy after enqueue", {enqReady, deqReady}, 0);
    @(negedge clk);
  endtask

  task automatic doDeq(input int f);
    deqValid = 1'b1; deqFlow = FW'(f);
    #1;
    while (!deqReady) begin @(negedge clk); #1; end
    if (model[f].size() == 0) begin
      expKind.push_back(1); expFlow.push_back(f); expData.push_back(0);
    end else begin
      expKind.push_back(0); expFlow.push_back(f); expData.push_back(model[f].pop_front());
      held--;
    end
    @(negedge clk);
    deqValid = 1'b0;
    #1;
    check(!enqReady && !deqReady, "R8 busy after dequeue", {enqReady, deqReady}, 0);
    @(negedge clk);
    check(outValid || deqErr, "R3 result timing", {outValid, deqErr}, 1);
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  endtask

  // watchdog
  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      mismatched++;
      $display("FAIL watchdog expired actual=%0d expected=<100000", cycles);
      finish_run();
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    #1;
    // R1: reset state
    check(enqReady == 1'b1, "R1 enqReady", enqReady, 1);
    check(deqReady == 1'b1, "R1 deqReady follows txEnable", deqReady, 1);
    check(!outValid && !deqErr && !enqFull, "R1 outputs low", {outValid, deqErr, enqFull}, 0);
    @(negedge clk);

    // R2/R3: interleaved flows keep their own order
    doEnq(0, 16'h0010); doEnq(1, 16'h0020); doEnq(0, 16'h0011);
    doEnq(2, 16'h0030); doEnq(0, 16'h0012);
    doDeq(1); doDeq(0); doDeq(2); doDeq(0); doDeq(0);

    // R4: empty flow refused, later use of the flow unaffected
    doDeq(3);
    doDeq(0);
    doEnq(3, 16'h0abc);
    doDeq(3);

    // R5/R6: fill every free slot, overflow, recycle
    for (int i = 0; i < CAP; i++) doEnq(i % NF, 16'h1000 + i);
    check(held == CAP, "R6 capacity reached in model", held, CAP);
    doEnq(1, 16'hdead);          // R5: refused with enqFull
    doDeq(2);                    // R6: frees one slot
    doEnq(3, 16'h2222);          // R6: slot reused by another flow
    doEnq(0, 16'hbeef);          // R5: full again
    for (int f = 0; f < NF; f++)
      while (model[f].size() > 0) doDeq(f);
    doDeq(1);                    // R4 after drain

    // R7: transmit disabled holds the dequeue off
    doEnq(1, 16'h0777);
    txEnable = 1'b0; deqValid = 1'b1; deqFlow = FW'(1);
    for (int i = 0; i < 5; i++) begin
      #1;
      check(deqReady == 1'b0, "R7 deqReady low when transmit off", deqReady, 0);
      @(negedge clk);
    end
    deqValid = 1'b0; txEnable = 1'b1;
    doDeq(1);                    // R7: data kept while held off

    // R9: enqueue and dequeue requested in the same cycle on an empty flow
    enqValid = 1'b1; enqFlow = FW'(2); enqData = 16'h0055;
    deqValid = 1'b1; deqFlow = FW'(2);
    #1;
    check(enqReady && !deqReady, "R9 enqueue wins", {enqReady, deqReady}, 2);
    model[2].push_back(16'h0055); held++;
    @(negedge clk);
    enqValid = 1'b0;
    #1;
    check(!deqReady, "R8 dequeue waits while busy", deqReady, 0);
    @(negedge clk);
    #1;
    check(deqReady, "R9 dequeue served next", deqReady, 1);
    expKind.push_back(0); expFlow.push_back(2); expData.push_back(model[2].pop_front()); held--;
    @(negedge clk);
    deqValid = 1'b0;
    @(negedge clk);
    check(outValid == 1'b1, "R9 dequeue returns the new word", outValid, 1);

    repeat (3) @(negedge clk);
    check(expKind.size() == 0, "R3 all expected results seen", expKind.size(), 0);
    finish_run();
  end
endmodule